// File: doc/BRIEF.md
# 24-bit accumulator instruction core

A compact multicycle processor for a word-oriented accumulator machine. Data words are 24 bits and memory is addressed in bytes. Every instruction is three bytes long: an 8-bit opcode, an index flag, and a 15-bit address field. The core reads each instruction one byte at a time through a single synchronous byte-wide memory port. It then forms a target address and carries out one of a small set of operations:

- loads and stores of the accumulator A, the index register X and the link register L;
- add, subtract and bitwise AND;
- signed compare;
- conditional and unconditional jumps;
- subroutine call and return through L;
- an increment-and-compare on X;
- moves of a single character byte;
- device test, read and write through a request/acknowledge port.

A program ends when the core meets an opcode it does not know. The core then raises a halt flag and stops.

The core is meant to sit beside a plain synchronous RAM. Read data returns one cycle after the address is presented. The device port serves any number of byte devices, each chosen by an 8-bit device code that the core reads from memory.

Top module: `acc24_core`

## Requirements
- R1: After reset the program counter equals RESET_PC (0 by default), so the first fetch presents address 0. A, X and L read as zero, the halt flag is low, no device request is active, and the condition code is "equal".
- R2: Bit 15 of an instruction word is the index flag. When it is 0 the target address is the low ADDR_W bits of field bits 14..0. When it is 1 it is that field plus X, truncated to ADDR_W bits.
- R3: A word is held in three consecutive bytes, most significant byte at the lowest address. Opcodes: LDA 0x00, LDX 0x04, LDL 0x08 load a register; STA 0x0C, STX 0x10, STL 0x14 store one.
- R4: ADD 0x18 and SUB 0x1C add the memory word to A or subtract it from A, in 24-bit two's complement with wraparound. AND 0x40 is a bitwise AND into A.
- R5: COMP 0x28 compares A with the memory word as signed numbers. TIX 0x2C adds 1 to X and then compares the new X with the word. Both set the condition code to less, equal or greater. Only COMP, TIX and TD change the condition code.
- R6: J 0x3C always jumps. JLT 0x38, JEQ 0x30 and JGT 0x34 jump only when the condition code is less, equal or greater. JSUB 0x48 stores the address of the following instruction in L and jumps. RSUB 0x4C jumps to the address in L.
- R7: LDCH 0x50 replaces only the low 8 bits of A with the byte at the target and leaves A[23:8] unchanged. STCH 0x54 writes only A[7:0] to the single byte at the target and leaves the neighbouring bytes untouched.
- R8: TD 0xE0 reads the device code from the byte at the target. It sets the condition code to less when dev_ready is high and to equal when dev_ready is low.
- R9: RD 0xD8 and WD 0xDC hold dev_req high, with dev_id set to the device code byte, until dev_ack is seen. RD puts dev_rdata into A[7:0] and keeps A[23:8]. WD drives A[7:0] on dev_wdata with dev_we high.
- R10: Any opcode not listed in R3 to R9 sets illegal_halt. The flag stays set, and the core makes no further memory writes until reset.
- R11: The program counter advances by 3 when an instruction fetch completes, before that instruction executes. A taken jump overwrites it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | ADDR_W | Byte address to memory |
| mem_we | output | 1 | Memory byte write enable |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid one cycle after its address |
| dev_id | output | 8 | Device code for TD, RD and WD |
| dev_req | output | 1 | Device transfer request, held until acknowledged |
| dev_we | output | 1 | High for a device write, low for a read |
| dev_wdata | output | 8 | Byte sent to the device |
| dev_rdata | input | 8 | Byte returned by the device |
| dev_ack | input | 1 | Device acknowledges the transfer |
| dev_ready | input | 1 | Readiness of the addressed device, sampled by TD |
| illegal_halt | output | 1 | Unknown opcode met; the core has stopped |

## Verification
The bench builds the core with ADDR_W set to 12 and RESET_PC left at 0. This gives a 4 KiB byte memory, small enough to clear in one cycle between programs. It still leaves the index flag and field bits 14..12 in the instruction, so indexed addressing and truncation of the field are both exercised. Each test loads a short program and runs it until an unknown opcode halts the core. The bench then judges results from the bytes the program stored and from what the device model recorded. The device model acknowledges only after several cycles, so the held request and the wait state are both exercised.

// File: rtl/acc24_pkg.sv
package acc24_pkg;

  localparam int WORD_W = 24;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {CC_LT = 2'd0, CC_EQ = 2'd1, CC_GT = 2'd2} cc_t;
  typedef enum logic [1:0] {ALU_PASS, ALU_ADD, ALU_SUB, ALU_AND} alu_op_t;
  typedef enum logic [1:0] {REG_A, REG_X, REG_L} reg_sel_t;
  typedef enum logic [1:0] {JC_ALWAYS, JC_LT, JC_EQ, JC_GT} jcond_t;
  typedef enum logic [3:0] {
    K_LOAD, K_STORE, K_ARITH, K_COMP, K_TIX, K_JUMP, K_JSUB, K_RSUB,
    K_LDCH, K_STCH, K_TD, K_RD, K_WD, K_ILLEGAL
  } kind_t;

  typedef struct packed {
    kind_t    kind;
    reg_sel_t rsel;
    alu_op_t  aop;
    jcond_t   jc;
  } dec_t;

  localparam logic [7:0] OP_LDA  = 8'h00;
  localparam logic [7:0] OP_LDX  = 8'h04;
  localparam logic [7:0] OP_LDL  = 8'h08;
  localparam logic [7:0] OP_STA  = 8'h0C;
  localparam logic [7:0] OP_STX  = 8'h10;
  localparam logic [7:0] OP_STL  = 8'h14;
  localparam logic [7:0] OP_ADD  = 8'h18;
  localparam logic [7:0] OP_SUB  = 8'h1C;
  localparam logic [7:0] OP_COMP = 8'h28;
  localparam logic [7:0] OP_TIX  = 8'h2C;
  localparam logic [7:0] OP_JEQ  = 8'h30;
  localparam logic [7:0] OP_JGT  = 8'h34;
  localparam logic [7:0] OP_JLT  = 8'h38;
  localparam logic [7:0] OP_J    = 8'h3C;
  localparam logic [7:0] OP_AND  = 8'h40;
  localparam logic [7:0] OP_JSUB = 8'h48;
  localparam logic [7:0] OP_RSUB = 8'h4C;
  localparam logic [7:0] OP_LDCH = 8'h50;
  localparam logic [7:0] OP_STCH = 8'h54;
  localparam logic [7:0] OP_RD   = 8'hD8;
  localparam logic [7:0] OP_WD   = 8'hDC;
  localparam logic [7:0] OP_TD   = 8'hE0;

  function automatic logic [WORD_W-1:0] alu_eval(alu_op_t op,
                                                 logic [WORD_W-1:0] lhs,
                                                 logic [WORD_W-1:0] rhs);
    case (op)
      ALU_ADD: return lhs + rhs;
      ALU_SUB: return lhs - rhs;
      ALU_AND: return lhs & rhs;
      default: return rhs;
    endcase
  endfunction

  function automatic cc_t cmp_code(logic [WORD_W-1:0] lhs, logic [WORD_W-1:0] rhs);
    if ($signed(lhs) < $signed(rhs)) return CC_LT;
    else if (lhs == rhs)             return CC_EQ;
    else                             return CC_GT;
  endfunction

  function automatic logic jump_ok(jcond_t jc, cc_t cc);
    case (jc)
      JC_LT:   return cc == CC_LT;
      JC_EQ:   return cc == CC_EQ;
      JC_GT:   return cc == CC_GT;
      default: return 1'b1;
    endcase
  endfunction

  // idx 0 selects the most significant byte of the word
  function automatic logic [BYTE_W-1:0] byte_of(logic [WORD_W-1:0] w, logic [1:0] idx);
    case (idx)
      2'd0:    return w[23:16];
      2'd1:    return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

endpackage

// File: rtl/acc24_decode.sv
module acc24_decode
  import acc24_pkg::*;
(
  input  logic [7:0] opcode,
  output dec_t       dec
);

  always_comb begin
    dec = '{kind: K_ILLEGAL, rsel: REG_A, aop: ALU_PASS, jc: JC_ALWAYS};
    case (opcode)
      OP_LDA:  dec.kind = K_LOAD;
      OP_LDX:  begin dec.kind = K_LOAD;  dec.rsel = REG_X; end
      OP_LDL:  begin dec.kind = K_LOAD;  dec.rsel = REG_L; end
      OP_STA:  dec.kind = K_STORE;
      OP_STX:  begin dec.kind = K_STORE; dec.rsel = REG_X; end
      OP_STL:  begin dec.kind = K_STORE; dec.rsel = REG_L; end
      OP_ADD:  begin dec.kind = K_ARITH; dec.aop = ALU_ADD; end
      OP_SUB:  begin dec.kind = K_ARITH; dec.aop = ALU_SUB; end
      OP_AND:  begin dec.kind = K_ARITH; dec.aop = ALU_AND; end
      OP_COMP: dec.kind = K_COMP;
      OP_TIX:  dec.kind = K_TIX;
      OP_J:    dec.kind = K_JUMP;
      OP_JLT:  begin dec.kind = K_JUMP; dec.jc = JC_LT; end
      OP_JEQ:  begin dec.kind = K_JUMP; dec.jc = JC_EQ; end
      OP_JGT:  begin dec.kind = K_JUMP; dec.jc = JC_GT; end
      OP_JSUB: dec.kind = K_JSUB;
      OP_RSUB: dec.kind = K_RSUB;
      OP_LDCH: dec.kind = K_LDCH;
      OP_STCH: dec.kind = K_STCH;
      OP_TD:   dec.kind = K_TD;
      OP_RD:   dec.kind = K_RD;
      OP_WD:   dec.kind = K_WD;
      default: dec.kind = K_ILLEGAL;
    endcase
  end

endmodule

// File: rtl/acc24_alu.sv
module acc24_alu
  import acc24_pkg::*;
(
  input  alu_op_t           aop,
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] idx,
  input  logic [WORD_W-1:0] operand,
  output logic [WORD_W-1:0] result,
  output logic [WORD_W-1:0] idx_inc,
  output cc_t               cmp_acc,
  output cc_t               cmp_idx
);

  assign result  = alu_eval(aop, acc, operand);
  assign idx_inc = idx + WORD_W'(1);
  assign cmp_acc = cmp_code(acc, operand);
  assign cmp_idx = cmp_code(idx_inc, operand);

endmodule

// File: rtl/acc24_core.sv
module acc24_core
  import acc24_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        dev_id,
  output logic              dev_req,
  output logic              dev_we,
  output logic [7:0]        dev_wdata,
  input  logic [7:0]        dev_rdata,
  input  logic              dev_ack,
  input  logic              dev_ready,
  output logic              illegal_halt
);

  localparam logic [1:0] INSN_BYTES = 2'd3;
  localparam logic [1:0] CHAR_BYTES = 2'd1;

  typedef enum logic [2:0] {S_IF, S_DEC, S_RD, S_WB, S_WR, S_IO, S_HALT} state_t;

  state_t            state;
  logic [1:0]        cnt;
  logic [1:0]        nb;
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] ta;
  logic [WORD_W-1:0] ir;
  logic [WORD_W-1:0] opd;
  logic [WORD_W-1:0] a;
  logic [WORD_W-1:0] x;
  logic [WORD_W-1:0] l;
  cc_t               cc;

  dec_t              dec;
  logic [WORD_W-1:0] alu_res;
  logic [WORD_W-1:0] x_inc;
  cc_t               cc_acc;
  cc_t               cc_idx;
  logic [ADDR_W-1:0] ta_next;
  logic [WORD_W-1:0] store_word;
  logic              byte_kind;

  // named events for the checker
  logic ev_fetch_done;
  logic ev_cc_write;
  logic in_fetch;

  acc24_decode u_dec (
    .opcode (ir[23:16]),
    .dec    (dec)
  );

  acc24_alu u_alu (
    .aop     (dec.aop),
    .acc     (a),
    .idx     (x),
    .operand (opd),
    .result  (alu_res),
    .idx_inc (x_inc),
    .cmp_acc (cc_acc),
    .cmp_idx (cc_idx)
  );

  function automatic logic [ADDR_W-1:0] target_of(logic [WORD_W-1:0] insn,
                                                  logic [WORD_W-1:0] xreg);
    logic [ADDR_W-1:0] offs;
    offs = insn[15] ? xreg[ADDR_W-1:0] : '0;
    return insn[ADDR_W-1:0] + offs;
  endfunction

  assign ta_next   = target_of(ir, x);
  assign byte_kind = (dec.kind == K_LDCH) || (dec.kind == K_STCH) ||
                     (dec.kind == K_TD)   || (dec.kind == K_RD)   ||
                     (dec.kind == K_WD);

  always_comb begin
    case (dec.rsel)
      REG_X:   store_word = x;
      REG_L:   store_word = l;
      default: store_word = a;
    endcase
  end

  assign in_fetch      = (state == S_IF);
  assign ev_fetch_done = in_fetch && (cnt == 2'd3);
  assign ev_cc_write   = (state == S_WB) &&
                         ((dec.kind == K_COMP) || (dec.kind == K_TIX) || (dec.kind == K_TD));

  assign mem_addr     = (in_fetch ? pc : ta) + ADDR_W'(cnt);
  assign mem_we       = (state == S_WR);
  assign mem_wdata    = byte_of(store_word, 2'(cnt + (INSN_BYTES - nb)));
  assign dev_req      = (state == S_IO);
  assign dev_we       = (dec.kind == K_WD);
  assign dev_id       = opd[7:0];
  assign dev_wdata    = a[7:0];
  assign illegal_halt = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IF;
      cnt   <= '0;
      nb    <= INSN_BYTES;
      pc    <= RESET_PC;
      ta    <= '0;
      ir    <= '0;
      opd   <= '0;
      a     <= '0;
      x     <= '0;
      l     <= '0;
      cc    <= CC_EQ;
    end else begin
      case (state)
        S_IF: begin
          if (cnt != 2'd0) ir <= {ir[15:0], mem_rdata};
          if (cnt == 2'd3) begin
            pc    <= pc + ADDR_W'(3);
            cnt   <= '0;
            state <= S_DEC;
          end else begin
            cnt <= cnt + 2'd1;
          end
        end
        S_DEC: begin
          ta  <= ta_next;
          opd <= '0;
          cnt <= '0;
          nb  <= byte_kind ? CHAR_BYTES : INSN_BYTES;
          case (dec.kind)
            K_LOAD, K_ARITH, K_COMP, K_TIX, K_LDCH, K_TD, K_RD, K_WD:
              state <= S_RD;
            K_STORE, K_STCH:
              state <= S_WR;
            K_JUMP: begin
              if (jump_ok(dec.jc, cc)) pc <= ta_next;
              state <= S_IF;
            end
            K_JSUB: begin
              l     <= WORD_W'(pc);
              pc    <= ta_next;
              state <= S_IF;
            end
            K_RSUB: begin
              pc    <= l[ADDR_W-1:0];
              state <= S_IF;
            end
            default: state <= S_HALT;
          endcase
        end
        S_RD: begin
          if (cnt != 2'd0) opd <= {opd[15:0], mem_rdata};
          if (cnt == nb) begin
            cnt   <= '0;
            state <= S_WB;
          end else begin
            cnt <= cnt + 2'd1;
          end
        end
        S_WB: begin
          case (dec.kind)
            K_LOAD: begin
              case (dec.rsel)
                REG_X:   x <= opd;
                REG_L:   l <= opd;
                default: a <= opd;
              endcase
            end
            K_ARITH: a <= alu_res;
            K_COMP:  cc <= cc_acc;
            K_TIX: begin
              x  <= x_inc;
              cc <= cc_idx;
            end
            K_LDCH:  a[7:0] <= opd[7:0];
            K_TD:    cc <= dev_ready ? CC_LT : CC_EQ;
            default: ;
          endcase
          state <= ((dec.kind == K_RD) || (dec.kind == K_WD)) ? S_IO : S_IF;
        end
        S_WR: begin
          if (cnt == nb - 2'd1) begin
            cnt   <= '0;
            state <= S_IF;
          end else begin
            cnt <= cnt + 2'd1;
          end
        end
        S_IO: begin
          if (dev_ack) begin
            if (dec.kind == K_RD) a[7:0] <= dev_rdata;
            state <= S_IF;
          end
        end
        S_HALT: state <= S_HALT;
        default: state <= S_HALT;
      endcase
    end
  end

endmodule

// File: rtl/acc24_core_chk.sv
module acc24_core_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] pc,
  input logic [1:0]        cc,
  input logic              ev_fetch_done,
  input logic              ev_cc_write,
  input logic              in_fetch,
  input logic              mem_we,
  input logic              illegal_halt,
  input logic              dev_req,
  input logic              dev_ack
);

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch_done |=> (pc - $past(pc)) == ADDR_W'(3)); // R11

  AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_cc_write |=> $stable(cc)); // R5

  AST_CC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cc != 2'b11); // R5

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_halt |=> (illegal_halt && !mem_we)); // R10

  AST_FETCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    in_fetch |-> !mem_we); // R3

  AST_DEV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && !dev_ack) |=> dev_req); // R9

endmodule

bind acc24_core acc24_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pc            (pc),
  .cc            (cc),
  .ev_fetch_done (ev_fetch_done),
  .ev_cc_write   (ev_cc_write),
  .in_fetch      (in_fetch),
  .mem_we        (mem_we),
  .illegal_halt  (illegal_halt),
  .dev_req       (dev_req),
  .dev_ack       (dev_ack)
);

// File: tb/acc24_core_tb.sv
module acc24_core_tb;

  localparam int AW  = 12;
  localparam int MEM = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata;
  logic [7:0]    dev_id;
  logic          dev_req;
  logic          dev_we;
  logic [7:0]    dev_wdata;
  logic [7:0]    dev_rdata;
  logic          dev_ack;
  logic          dev_ready;
  logic          illegal_halt;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  acc24_core #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_id(dev_id), .dev_req(dev_req), .dev_we(dev_we), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata), .dev_ack(dev_ack), .dev_ready(dev_ready),
    .illegal_halt(illegal_halt)
  );

  // memory model with a loader port
  logic [7:0]    mem [MEM];
  logic          clr = 1'b0;
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0]    ld_data = '0;

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < MEM; i++) mem[i] <= 8'h00;
    end else if (ld_en) begin
      mem[ld_addr] <= ld_data;
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
    mem_rdata <= mem[mem_addr];
  end

  // device model: acknowledges on the third request cycle
  logic [1:0] dcnt;
  logic [7:0] wr_byte;
  logic [7:0] wr_id;
  int         req_cnt;
  assign dev_rdata = 8'h5A;

  always @(posedge clk) begin
    if (clr) req_cnt <= 0;
    else if (dev_req) req_cnt <= req_cnt + 1;
    if (!rst_n) begin
      dev_ack <= 1'b0;
      dcnt    <= 2'd0;
    end else if (dev_ack) begin
      dev_ack <= 1'b0;
    end else if (dev_req) begin
      if (dcnt == 2'd2) begin
        dev_ack <= 1'b1;
        dcnt    <= 2'd0;
        if (dev_we) begin
          wr_byte <= dev_wdata;
          wr_id   <= dev_id;
        end
      end else begin
        dcnt <= dcnt + 2'd1;
      end
    end
  end

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %06h expected %06h", req, act, exp);
    end
  endtask

  task automatic put_b(int a, logic [7:0] d);
    ld_en = 1'b1; ld_addr = AW'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic put_w(int a, logic [23:0] w);
    put_b(a, w[23:16]); put_b(a + 1, w[15:8]); put_b(a + 2, w[7:0]);
  endtask

  task automatic put_i(int a, logic [7:0] op, logic xf, logic [14:0] field);
    put_w(a, {op, xf, field});
  endtask

  function automatic logic [23:0] get_w(int a);
    return {mem[a], mem[a + 1], mem[a + 2]};
  endfunction

  task automatic prep();
    @(negedge clk);
    rst_n = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic run_prog(string req);
    int n;
    n = 0;
    @(negedge clk);
    rst_n = 1'b1;
    while (!illegal_halt && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!illegal_halt) begin
      tests++; fails++;
      $display("FAIL %s: program did not halt, actual 0 expected 1", req);
    end
  endtask

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] va;
    logic [23:0] vb;
    logic [23:0] res;
    logic [23:0] ccm;
  } vec_t;

  // cc markers: 1 = less, 2 = equal, 3 = greater
  localparam vec_t VEC [9] = '{
    '{8'h18, 24'h000005, 24'h000007, 24'h00000C, 24'd2},  // R4 add
    '{8'h18, 24'hFFFFFF, 24'h000002, 24'h000001, 24'd2},  // R4 add wraps
    '{8'h1C, 24'h000003, 24'h000005, 24'hFFFFFE, 24'd2},  // R4 sub
    '{8'h40, 24'hF0F0F0, 24'h0FF00F, 24'h00F000, 24'd2},  // R4 and
    '{8'h28, 24'h000005, 24'h000007, 24'h000005, 24'd1},  // R5 less
    '{8'h28, 24'h000007, 24'h000007, 24'h000007, 24'd2},  // R5 equal
    '{8'h28, 24'h800000, 24'h000001, 24'h800000, 24'd1},  // R5 signed less
    '{8'h28, 24'h000001, 24'hFFFFFF, 24'h000001, 24'd3},  // R5 greater
    '{8'h00, 24'h000005, 24'h0ABCDE, 24'h0ABCDE, 24'd2}   // R3 load
  };

  initial begin
    #(4 * 190000);
    fails++; tests++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    dev_ready = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    prep();
    check("R1 first fetch address", 24'(mem_addr), 24'h0);
    check("R1 halt low", 24'(illegal_halt), 24'h0);
    check("R1 no device request", 24'(dev_req), 24'h0);
    put_i(0, 8'h0C, 1'b0, 15'h200);
    put_i(3, 8'h10, 1'b0, 15'h203);
    put_i(6, 8'h14, 1'b0, 15'h206);
    put_i(9, 8'hFC, 1'b0, 15'h0);
    run_prog("R1");
    check("R1 A zero", get_w(12'h200), 24'h0);
    check("R1 X zero", get_w(12'h203), 24'h0);
    check("R1 L zero", get_w(12'h206), 24'h0);

    // vector table: arithmetic, compare, branches
    foreach (VEC[k]) begin
      prep();
      put_w(12'h100, VEC[k].va);
      put_w(12'h103, VEC[k].vb);
      put_w(12'h10C, 24'd1);
      put_w(12'h10F, 24'd2);
      put_w(12'h112, 24'd3);
      put_i(0,  8'h00, 1'b0, 15'h100);
      put_i(3,  VEC[k].op, 1'b0, 15'h103);
      put_i(6,  8'h0C, 1'b0, 15'h106);
      put_i(9,  8'h38, 1'b0, 15'd21);
      put_i(12, 8'h30, 1'b0, 15'd27);
      put_i(15, 8'h00, 1'b0, 15'h112);
      put_i(18, 8'h3C, 1'b0, 15'd30);
      put_i(21, 8'h00, 1'b0, 15'h10C);
      put_i(24, 8'h3C, 1'b0, 15'd30);
      put_i(27, 8'h00, 1'b0, 15'h10F);
      put_i(30, 8'h0C, 1'b0, 15'h109);
      put_i(33, 8'hFC, 1'b0, 15'h0);
      run_prog("R6 vector");
      check($sformatf("R4 vector %0d result", k), get_w(12'h106), VEC[k].res);
      check($sformatf("R5 R6 vector %0d condition path", k), get_w(12'h109), VEC[k].ccm);
    end

    // R2 indexing, R3 register loads and stores
    prep();
    put_w(12'h100, 24'h000006);
    put_w(12'h110, 24'h111111);
    put_w(12'h116, 24'hC0FFEE);
    put_w(12'h120, 24'h654321);
    put_i(0,  8'h00, 1'b0, 15'h100);
    put_i(0,  8'h04, 1'b0, 15'h100);
    put_i(3,  8'h00, 1'b1, 15'h110);
    put_i(6,  8'h0C, 1'b0, 15'h200);
    put_i(9,  8'h08, 1'b0, 15'h120);
    put_i(12, 8'h14, 1'b1, 15'h200);
    put_i(15, 8'h10, 1'b0, 15'h209);
    put_i(18, 8'hFC, 1'b0, 15'h0);
    run_prog("R2");
    check("R2 indexed load", get_w(12'h200), 24'hC0FFEE);
    check("R3 high byte first", 24'(mem[12'h200]), 24'h0000C0);
    check("R3 low byte last", 24'(mem[12'h202]), 24'h0000EE);
    check("R2 R3 indexed store of L", get_w(12'h206), 24'h654321);
    check("R3 store of X", get_w(12'h209), 24'h000006);

    // R6 subroutine call and return, R11 link value
    prep();
    put_w(12'h100, 24'h00ABCD);
    put_i(0,    8'h48, 1'b0, 15'h030);
    put_i(3,    8'h14, 1'b0, 15'h200);
    put_i(6,    8'hFC, 1'b0, 15'h0);
    put_i(12'h30, 8'h00, 1'b0, 15'h100);
    put_i(12'h33, 8'h0C, 1'b0, 15'h203);
    put_i(12'h36, 8'h4C, 1'b0, 15'h0);
    run_prog("R6");
    check("R6 R11 link holds next address", get_w(12'h200), 24'h000003);
    check("R6 subroutine body ran", get_w(12'h203), 24'h00ABCD);

    // R5 increment-and-test loop
    prep();
    put_w(12'h100, 24'h000003);
    put_i(0, 8'h2C, 1'b0, 15'h100);
    put_i(3, 8'h38, 1'b0, 15'h000);
    put_i(6, 8'h10, 1'b0, 15'h200);
    put_i(9, 8'hFC, 1'b0, 15'h0);
    run_prog("R5");
    check("R5 TIX loop final X", get_w(12'h200), 24'h000003);

    // R7 character moves
    prep();
    put_w(12'h100, 24'h123456);
    put_b(12'h104, 8'hCD);
    put_b(12'h105, 8'hAB);
    put_b(12'h210, 8'h11);
    put_b(12'h211, 8'h22);
    put_b(12'h212, 8'h33);
    put_i(0, 8'h00, 1'b0, 15'h100);
    put_i(3, 8'h50, 1'b0, 15'h105);
    put_i(6, 8'h0C, 1'b0, 15'h200);
    put_i(9, 8'h54, 1'b0, 15'h211);
    put_i(12, 8'hFC, 1'b0, 15'h0);
    run_prog("R7");
    check("R7 LDCH keeps upper bits", get_w(12'h200), 24'h1234AB);
    check("R7 STCH target byte", 24'(mem[12'h211]), 24'h0000AB);
    check("R7 STCH byte before untouched", 24'(mem[12'h210]), 24'h000011);
    check("R7 STCH byte after untouched", 24'(mem[12'h212]), 24'h000033);

    // R8 device test, ready then busy
    for (int r = 1; r >= 0; r--) begin
      prep();
      dev_ready = r[0];
      put_b(12'h100, 8'h05);
      put_w(12'h110, 24'd1);
      put_w(12'h113, 24'd2);
      put_i(0,  8'hE0, 1'b0, 15'h100);
      put_i(3,  8'h30, 1'b0, 15'd12);
      put_i(6,  8'h00, 1'b0, 15'h110);
      put_i(9,  8'h3C, 1'b0, 15'd15);
      put_i(12, 8'h00, 1'b0, 15'h113);
      put_i(15, 8'h0C, 1'b0, 15'h200);
      put_i(18, 8'hFC, 1'b0, 15'h0);
      run_prog("R8");
      check($sformatf("R8 TD with ready=%0d", r), get_w(12'h200), r ? 24'd1 : 24'd2);
    end

    // R9 device read and write
    prep();
    put_w(12'h120, 24'hABCD00);
    put_b(12'h100, 8'h07);
    put_i(0,  8'h00, 1'b0, 15'h120);
    put_i(3,  8'hD8, 1'b0, 15'h100);
    put_i(6,  8'h0C, 1'b0, 15'h200);
    put_i(9,  8'hDC, 1'b0, 15'h100);
    put_i(12, 8'hFC, 1'b0, 15'h0);
    run_prog("R9");
    check("R9 RD fills low byte only", get_w(12'h200), 24'hABCD5A);
    check("R9 WD byte", 24'(wr_byte), 24'h00005A);
    check("R9 WD device code", 24'(wr_id), 24'h000007);
    check("R9 request held until ack", 24'(req_cnt), 24'd8);

    // R10 unknown opcode halts, later store never happens
    prep();
    put_b(12'h200, 8'h77);
    put_i(0, 8'h44, 1'b0, 15'h0);
    put_i(3, 8'h0C, 1'b0, 15'h200);
    run_prog("R10");
    repeat (30) @(negedge clk);
    check("R10 halt stays set", 24'(illegal_halt), 24'h1);
    check("R10 no write after halt", 24'(mem[12'h200]), 24'h000077);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule